// File: doc/BRIEF.md
# Touch Baseline Tracker

This block keeps a calibrated baseline for each of eight capacitive touch channels. Every new 8-bit capacitance sample of a channel is compared with that channel's baseline to give a raw touch or no-touch bit. A sample counts as a touch when it rises above the baseline by more than the channel's own touch margin. While no channel is touched, the block moves the baselines slowly so that they follow environmental drift.

Tracking uses two thresholds. A rise that stays within the global drift margin, and any fall, pulls the baseline onto the sample. A rise above the drift margin that is still not a touch freezes the baseline. Automatic tracking waits until all channels have been quiet for a programmable number of sensor ticks, and then repeats at a programmable spacing. A hold control stops automatic tracking and gives control to the host. The host can then force a reload of all baselines, either unconditionally or only when no channel is touched.

The analog front end, the register decoding and any later filtering stay outside the block. A sample strobe, a sensor tick and the host command requests reach the block as single-cycle inputs.

Top module: `touch_baseline_tracker`

## Requirements
- R1: On a strobe of channel i, touch_raw_o[i] takes the value (sample > baseline + tvr_i field), computed without wrap in 9-bit arithmetic with a 7-bit margin. The bit is visible one cycle after the strobe and holds until the next strobe of that channel. Channel i uses bits [8i+7:8i] of the sample and baseline vectors and bits [7i+6:7i] of tvr_i.
- R2: At an automatic calibration, a channel whose last sample is more than evr_i above its baseline keeps its baseline.
- R3: At an automatic calibration, a channel whose last sample is above its baseline by at most evr_i takes that sample as its baseline.
- R4: At an automatic calibration, a channel whose last sample is below its baseline takes that sample as its baseline.
- R5: A quiet counter advances on each sensor tick while no raw touch bit is set, and saturates at wait_cfg_i×64. Any set raw touch bit clears it. An automatic calibration can happen only on a tick that finds the counter at its limit, so the first one after a quiet start falls on tick wait_cfg_i×64+1.
- R6: The first automatic calibration happens on the first tick on which R5 allows it. Further automatic calibrations follow every intv_cfg_i×50 ticks while the quiet condition lasts. A raw touch restarts this sequence.
- R7: While hold_i is high, no automatic calibration happens. While hold_i is low, host requests are ignored and their busy bits stay low.
- R8: An unconditional request under hold_i sets ucal_busy_o for one cycle. That cycle reloads every baseline with its channel's last sample, and the bit then clears.
- R9: A conditional request under hold_i sets ccal_busy_o for one cycle. That cycle reloads the baselines only if no raw touch bit is set, and the bit clears in either case.
- R10: cal_done_o pulses in the cycle after each automatic or host reload. It stays low after a skipped conditional request.
- R11: After reset, all baselines, stored samples, raw touch bits, busy bits and cal_done_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| sens_tick_i | input | 1 | One-cycle sensor clock tick |
| smp_vld_i | input | NUM_CH | Per-channel sample strobe |
| smp_data_i | input | NUM_CH*8 | Per-channel samples, channel i at [8i+7:8i] |
| tvr_i | input | NUM_CH*7 | Per-channel touch margin, channel i at [7i+6:7i] |
| evr_i | input | 7 | Global drift margin |
| wait_cfg_i | input | 8 | Quiet wait, in units of 64 ticks |
| intv_cfg_i | input | 8 | Calibration spacing, in units of 50 ticks |
| hold_i | input | 1 | Stops automatic tracking, enables host requests |
| ucal_req_i | input | 1 | Unconditional host calibration request |
| ccal_req_i | input | 1 | Conditional host calibration request |
| touch_raw_o | output | NUM_CH | Raw per-channel touch decision |
| base_o | output | NUM_CH*8 | Calibrated baselines, channel i at [8i+7:8i] |
| ucal_busy_o | output | 1 | Unconditional command pending |
| ccal_busy_o | output | 1 | Conditional command pending |
| cal_done_o | output | 1 | End-of-calibration pulse |

## Verification
The assertions check on every cycle the properties that need no arithmetic. Baselines stay frozen under hold when no command is pending. An automatic calibration never happens with a touch present or under hold. Command bits clear themselves. Any baseline change comes with cal_done_o, and a raw touch rises only after a strobe. The classification arithmetic, the split among the three tracking outcomes, and the exact tick counts of the quiet wait and the calibration spacing only show in the bench. Its directed scenarios cover these, including a margin that would wrap in 8 bits, and a per-cycle reference model backs them up under random strobes, ticks and commands.

// File: rtl/tbt_pkg.sv
package tbt_pkg;
  localparam int SMP_W      = 8;
  localparam int VAR_W      = 7;
  localparam int CFG_W      = 8;
  localparam int WAIT_SHIFT = 6;
  localparam int INTV_MULT  = 50;
  localparam int WCNT_W     = CFG_W + WAIT_SHIFT;
  localparam int ICNT_W     = CFG_W + $clog2(INTV_MULT);

  typedef logic [SMP_W:0]    ext_t;
  typedef logic [WCNT_W-1:0] wcnt_t;
  typedef logic [ICNT_W-1:0] icnt_t;

  // Raw touch: sample strictly above baseline plus margin, 9-bit compare.
  function automatic logic over_margin(input logic [SMP_W-1:0] smp,
                                       input logic [SMP_W-1:0] base,
                                       input logic [VAR_W-1:0] tvr);
    ext_t lhs;
    ext_t rhs;
    lhs = ext_t'(smp);
    rhs = ext_t'(base) + ext_t'(tvr);
    return lhs > rhs;
  endfunction

  // Drift tracking: follow any fall or a rise within the drift margin.
  function automatic logic [SMP_W-1:0] track_base(input logic [SMP_W-1:0] smp,
                                                  input logic [SMP_W-1:0] base,
                                                  input logic [VAR_W-1:0] evr);
    ext_t lim;
    lim = ext_t'(base) + ext_t'(evr);
    if (ext_t'(smp) <= lim) return smp;
    return base;
  endfunction

  function automatic wcnt_t wait_limit(input logic [CFG_W-1:0] cfg);
    return wcnt_t'(cfg) << WAIT_SHIFT;
  endfunction

  function automatic icnt_t intv_reload(input logic [CFG_W-1:0] cfg);
    icnt_t span;
    span = icnt_t'(cfg) * icnt_t'(INTV_MULT);
    if (span == '0) return '0;
    return span - icnt_t'(1);
  endfunction
endpackage

// File: rtl/tbt_channel.sv
module tbt_channel
  import tbt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_vld_i,
  input  logic [SMP_W-1:0] smp_i,
  input  logic [VAR_W-1:0] tvr_i,
  input  logic [VAR_W-1:0] evr_i,
  input  logic             track_i,
  input  logic             load_i,
  output logic             touch_o,
  output logic [SMP_W-1:0] base_o
);
  logic [SMP_W-1:0] last_q;
  logic [SMP_W-1:0] base_q;
  logic             touch_q;
  logic             hit;

  assign hit = over_margin(smp_i, base_q, tvr_i);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      last_q  <= '0;
      touch_q <= 1'b0;
    end else if (smp_vld_i) begin
      last_q  <= smp_i;
      touch_q <= hit;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      base_q <= '0;
    end else if (load_i) begin
      base_q <= last_q;
    end else if (track_i) begin
      base_q <= track_base(last_q, base_q, evr_i);
    end
  end

  assign touch_o = touch_q;
  assign base_o  = base_q;
endmodule

// File: rtl/tbt_quiet_timer.sv
module tbt_quiet_timer
  import tbt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             any_touch_i,
  input  logic             hold_i,
  input  logic [CFG_W-1:0] wait_cfg_i,
  input  logic [CFG_W-1:0] intv_cfg_i,
  output logic             wait_done_o,
  output logic             auto_evt_o
);
  wcnt_t wait_q;
  icnt_t intv_q;
  wcnt_t limit;

  assign limit       = wait_limit(wait_cfg_i);
  assign wait_done_o = (wait_q >= limit);
  assign auto_evt_o  = tick_i && !hold_i && !any_touch_i && wait_done_o && (intv_q == '0);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      wait_q <= '0;
    end else if (any_touch_i) begin
      wait_q <= '0;
    end else if (tick_i && (wait_q < limit)) begin
      wait_q <= wait_q + wcnt_t'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      intv_q <= '0;
    end else if (any_touch_i) begin
      intv_q <= '0;
    end else if (auto_evt_o) begin
      intv_q <= intv_reload(intv_cfg_i);
    end else if (tick_i && !hold_i && wait_done_o && (intv_q != '0)) begin
      intv_q <= intv_q - icnt_t'(1);
    end
  end
endmodule

// File: rtl/tbt_host_cmd.sv
module tbt_host_cmd (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic ureq_i,
  input  logic creq_i,
  input  logic any_touch_i,
  output logic ubusy_o,
  output logic cbusy_o,
  output logic load_o
);
  logic ubusy_q;
  logic cbusy_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      ubusy_q <= 1'b0;
      cbusy_q <= 1'b0;
    end else begin
      ubusy_q <= ureq_i && hold_i;
      cbusy_q <= creq_i && hold_i;
    end
  end

  assign load_o  = hold_i && (ubusy_q || (cbusy_q && !any_touch_i));
  assign ubusy_o = ubusy_q;
  assign cbusy_o = cbusy_q;
endmodule

// File: rtl/touch_baseline_tracker.sv
module touch_baseline_tracker
  import tbt_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sens_tick_i,
  input  logic [NUM_CH-1:0]       smp_vld_i,
  input  logic [NUM_CH*SMP_W-1:0] smp_data_i,
  input  logic [NUM_CH*VAR_W-1:0] tvr_i,
  input  logic [VAR_W-1:0]        evr_i,
  input  logic [CFG_W-1:0]        wait_cfg_i,
  input  logic [CFG_W-1:0]        intv_cfg_i,
  input  logic                    hold_i,
  input  logic                    ucal_req_i,
  input  logic                    ccal_req_i,
  output logic [NUM_CH-1:0]       touch_raw_o,
  output logic [NUM_CH*SMP_W-1:0] base_o,
  output logic                    ucal_busy_o,
  output logic                    ccal_busy_o,
  output logic                    cal_done_o
);
  logic any_touch;
  logic auto_evt;
  logic host_load;
  logic wait_done;
  logic done_q;

  assign any_touch = |touch_raw_o;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    tbt_channel u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .smp_vld_i(smp_vld_i[g]),
      .smp_i    (smp_data_i[g*SMP_W +: SMP_W]),
      .tvr_i    (tvr_i[g*VAR_W +: VAR_W]),
      .evr_i    (evr_i),
      .track_i  (auto_evt),
      .load_i   (host_load),
      .touch_o  (touch_raw_o[g]),
      .base_o   (base_o[g*SMP_W +: SMP_W])
    );
  end

  tbt_quiet_timer u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (sens_tick_i),
    .any_touch_i(any_touch),
    .hold_i     (hold_i),
    .wait_cfg_i (wait_cfg_i),
    .intv_cfg_i (intv_cfg_i),
    .wait_done_o(wait_done),
    .auto_evt_o (auto_evt)
  );

  tbt_host_cmd u_cmd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hold_i     (hold_i),
    .ureq_i     (ucal_req_i),
    .creq_i     (ccal_req_i),
    .any_touch_i(any_touch),
    .ubusy_o    (ucal_busy_o),
    .cbusy_o    (ccal_busy_o),
    .load_o     (host_load)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= auto_evt || host_load;
  end

  assign cal_done_o = done_q;
endmodule

// File: rtl/touch_baseline_tracker_chk.sv
module touch_baseline_tracker_chk #(
  parameter int NUM_CH = 8,
  parameter int SMP_W  = 8
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    hold_i,
  input logic                    ucal_req_i,
  input logic                    ccal_req_i,
  input logic [NUM_CH-1:0]       smp_vld_i,
  input logic [NUM_CH-1:0]       touch_raw_o,
  input logic [NUM_CH*SMP_W-1:0] base_o,
  input logic                    ucal_busy_o,
  input logic                    ccal_busy_o,
  input logic                    cal_done_o,
  input logic                    auto_evt
);
  AST_HOLD_FREEZES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !ucal_busy_o && !ccal_busy_o) |=> $stable(base_o)); // R7
  AST_AUTO_NOT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_evt |-> !hold_i); // R7
  AST_BUSY_NEEDS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ucal_busy_o) |-> $past(hold_i)); // R7
  AST_AUTO_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_evt |-> (touch_raw_o == '0)); // R5
  AST_UCAL_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ucal_busy_o && !ucal_req_i) |=> !ucal_busy_o); // R8
  AST_CCAL_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ccal_busy_o && !ccal_req_i) |=> !ccal_busy_o); // R9
  AST_BASE_MOVE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(base_o) |-> cal_done_o); // R10

  for (genvar g = 0; g < NUM_CH; g++) begin : g_tc
    AST_TOUCH_NEEDS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(touch_raw_o[g]) |-> $past(smp_vld_i[g])); // R1
  end
endmodule

bind touch_baseline_tracker touch_baseline_tracker_chk #(
  .NUM_CH(NUM_CH),
  .SMP_W (tbt_pkg::SMP_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .hold_i     (hold_i),
  .ucal_req_i (ucal_req_i),
  .ccal_req_i (ccal_req_i),
  .smp_vld_i  (smp_vld_i),
  .touch_raw_o(touch_raw_o),
  .base_o     (base_o),
  .ucal_busy_o(ucal_busy_o),
  .ccal_busy_o(ccal_busy_o),
  .cal_done_o (cal_done_o),
  .auto_evt   (auto_evt)
);

// File: tb/touch_baseline_tracker_test.sv
`timescale 1ns/1ps
module touch_baseline_tracker_test;
  localparam int NC = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          b_tick, b_hold, b_ureq, b_creq;
  logic [NC-1:0] b_vld;
  int            b_smp [NC];
  int            b_tvr [NC];
  int            b_evr, b_wait, b_intv;

  logic [NC*8-1:0] smp_flat;
  logic [NC*7-1:0] tvr_flat;
  always_comb begin
    for (int i = 0; i < NC; i++) begin
      smp_flat[i*8 +: 8] = 8'(b_smp[i]);
      tvr_flat[i*7 +: 7] = 7'(b_tvr[i]);
    end
  end

  logic [NC-1:0]   touch_raw;
  logic [NC*8-1:0] base;
  logic            ubusy, cbusy, done;

  touch_baseline_tracker #(.NUM_CH(NC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sens_tick_i(b_tick), .smp_vld_i(b_vld),
    .smp_data_i(smp_flat), .tvr_i(tvr_flat), .evr_i(7'(b_evr)),
    .wait_cfg_i(8'(b_wait)), .intv_cfg_i(8'(b_intv)), .hold_i(b_hold),
    .ucal_req_i(b_ureq), .ccal_req_i(b_creq), .touch_raw_o(touch_raw),
    .base_o(base), .ucal_busy_o(ubusy), .ccal_busy_o(cbusy), .cal_done_o(done)
  );

  // Reference model state
  int m_base [NC];
  int m_last [NC];
  bit m_touch [NC];
  int m_wait, m_intv;
  bit m_u, m_c, m_done;

  int n_chk = 0;
  int n_fail = 0;
  string cur_req = "R1";

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int dut_base(input int i);
    return int'(base[i*8 +: 8]);
  endfunction

  task automatic model_update();
    bit any_t, expired, auto_c, hload;
    int limit, reload, nb [NC];
    any_t = 0;
    for (int i = 0; i < NC; i++) any_t |= m_touch[i];
    limit   = b_wait * 64;
    expired = (m_wait >= limit);
    auto_c  = b_tick && !b_hold && !any_t && expired && (m_intv == 0);
    hload   = b_hold && (m_u || (m_c && !any_t));
    reload  = (b_intv * 50 == 0) ? 0 : b_intv * 50 - 1;
    for (int i = 0; i < NC; i++) begin
      nb[i] = m_base[i];
      if (hload) nb[i] = m_last[i];
      else if (auto_c && (m_last[i] - m_base[i] <= b_evr)) nb[i] = m_last[i];
      if (b_vld[i]) begin
        m_touch[i] = (b_smp[i] - m_base[i]) > b_tvr[i];
        m_last[i]  = b_smp[i];
      end
    end
    for (int i = 0; i < NC; i++) m_base[i] = nb[i];
    if (any_t) begin
      m_wait = 0;
      m_intv = 0;
    end else begin
      if (b_tick && m_wait < limit) m_wait++;
      if (auto_c) m_intv = reload;
      else if (b_tick && !b_hold && expired && m_intv != 0) m_intv--;
    end
    m_u    = b_ureq && b_hold;
    m_c    = b_creq && b_hold;
    m_done = auto_c || hload;
  endtask

  task automatic step();
    int bad;
    logic [NC-1:0] exp_t;
    @(posedge clk);
    model_update();
    @(negedge clk);
    for (int i = 0; i < NC; i++) exp_t[i] = m_touch[i];
    chk(touch_raw == exp_t, cur_req, "touch_raw", int'(touch_raw), int'(exp_t));
    bad = -1;
    for (int i = 0; i < NC; i++) if (dut_base(i) != m_base[i] && bad < 0) bad = i;
    chk(bad < 0, cur_req, "baseline", (bad < 0) ? 0 : dut_base(bad),
        (bad < 0) ? 0 : m_base[bad]);
    chk({ubusy, cbusy} == {m_u, m_c}, "R8", "busy bits", int'({ubusy, cbusy}), int'({m_u, m_c}));
    chk(done == m_done, "R10", "cal_done", int'(done), int'(m_done));
    b_vld = '0; b_tick = 0; b_ureq = 0; b_creq = 0;
  endtask

  task automatic strobe(input int ch, input int val);
    b_vld[ch] = 1'b1;
    b_smp[ch] = val;
  endtask

  function automatic int ticks_to_done_limit();
    return 600;
  endfunction

  task automatic ticks_until_done(output int n);
    n = 0;
    do begin
      b_tick = 1;
      step();
      n++;
    end while (!done && n < ticks_to_done_limit());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n, v;
    void'($urandom(32'd20240611));
    b_tick = 0; b_hold = 1; b_ureq = 0; b_creq = 0; b_vld = '0;
    b_evr = 4; b_wait = 1; b_intv = 1;
    for (int i = 0; i < NC; i++) begin
      b_smp[i] = 0; b_tvr[i] = 8;
      m_base[i] = 0; m_last[i] = 0; m_touch[i] = 0;
    end
    m_wait = 0; m_intv = 0; m_u = 0; m_c = 0; m_done = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    chk(base == '0, "R11", "baselines after reset", 0, 0);
    chk(touch_raw == '0 && !ubusy && !cbusy && !done, "R11", "flags after reset",
        int'({touch_raw, ubusy, cbusy, done}), 0);

    // R1 threshold edge, baseline 0, margin 8
    cur_req = "R1";
    strobe(0, 8); step();
    chk(touch_raw[0] == 1'b0, "R1", "sample equal to margin", int'(touch_raw[0]), 0);
    strobe(0, 9); step();
    chk(touch_raw[0] == 1'b1, "R1", "sample above margin", int'(touch_raw[0]), 1);
    step();
    chk(touch_raw[0] == 1'b1, "R1", "touch held without strobe", int'(touch_raw[0]), 1);

    // R9 conditional skipped while touched
    cur_req = "R9";
    b_creq = 1; step();
    chk(cbusy == 1'b1, "R9", "conditional busy set", int'(cbusy), 1);
    step();
    chk(cbusy == 1'b0 && done == 1'b0 && dut_base(0) == 0, "R9", "skipped conditional",
        int'({cbusy, done}), 0);

    // R8 unconditional reload
    cur_req = "R8";
    for (int i = 0; i < NC; i++) strobe(i, 100);
    step();
    b_ureq = 1; step();
    chk(ubusy == 1'b1, "R8", "unconditional busy set", int'(ubusy), 1);
    step();
    chk(dut_base(3) == 100 && ubusy == 1'b0, "R8", "unconditional reload ch3", dut_base(3), 100);
    chk(done == 1'b1, "R10", "done after host reload", int'(done), 1);

    // R9 conditional applied when quiet
    cur_req = "R9";
    for (int i = 0; i < NC; i++) strobe(i, 100);
    strobe(1, 95);
    step();
    b_creq = 1; step(); step();
    chk(dut_base(1) == 95, "R9", "conditional reload ch1", dut_base(1), 95);

    // R7 host requests ignored without hold
    cur_req = "R7";
    b_hold = 0;
    b_ureq = 1; step();
    chk(ubusy == 1'b0, "R7", "request ignored without hold", int'(ubusy), 0);

    // R2 R3 R4 via first automatic calibration; R5 timing
    cur_req = "R3";
    strobe(2, 103); strobe(3, 106); strobe(4, 90);
    step();
    ticks_until_done(n);
    chk(n == 65, "R5", "ticks to first auto calibration", n, 65);
    chk(dut_base(2) == 103, "R3", "small rise tracked", dut_base(2), 103);
    chk(dut_base(3) == 100, "R2", "moderate rise frozen", dut_base(3), 100);
    chk(dut_base(4) == 90, "R4", "fall tracked", dut_base(4), 90);

    // R6 spacing
    cur_req = "R6";
    ticks_until_done(n);
    chk(n == 50, "R6", "ticks between auto calibrations", n, 50);

    // R5 restart on touch
    cur_req = "R5";
    strobe(5, 200); step();
    chk(touch_raw[5] == 1'b1, "R1", "touch on ch5", int'(touch_raw[5]), 1);
    b_tick = 1; step();
    strobe(5, 100); step();
    ticks_until_done(n);
    chk(n == 65, "R5", "wait restarted by touch", n, 65);

    // R1 no wrap: baseline 250, margin 127, sample 255
    cur_req = "R1";
    b_hold = 1;
    b_tvr[6] = 127;
    strobe(6, 250); step();
    b_ureq = 1; step(); step();
    chk(dut_base(6) == 250, "R8", "reload ch6", dut_base(6), 250);
    strobe(6, 255); step();
    chk(touch_raw[6] == 1'b0, "R1", "9-bit margin no wrap", int'(touch_raw[6]), 0);

    // Random phase against the model
    for (int i = 0; i < NC; i++) b_tvr[i] = $urandom_range(2, 12);
    for (int c = 0; c < 12000; c++) begin
      if (c % 1000 == 0) begin
        b_wait = $urandom_range(0, 1);
        b_intv = $urandom_range(0, 1);
        b_evr  = $urandom_range(0, 5);
      end
      if (c % 200 == 0) b_hold = ($urandom_range(0, 2) == 0);
      cur_req = (c % 2 == 0) ? "R3" : "R4";
      for (int i = 0; i < NC; i++) begin
        if ($urandom_range(0, 3) == 0) begin
          v = m_base[i] + int'($urandom_range(0, 24)) - 8;
          if ($urandom_range(0, 15) == 0) v = $urandom_range(0, 255);
          if (v < 0) v = 0;
          if (v > 255) v = 255;
          strobe(i, v);
        end
      end
      b_tick = $urandom_range(0, 1);
      b_ureq = ($urandom_range(0, 15) == 0);
      b_creq = ($urandom_range(0, 15) == 0);
      step();
    end

    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule